// File: doc/BRIEF.md
# GPIO Port Controller Register Block

This block is the register front end of a 32-pin general-purpose I/O port. A simple word-addressed register bus (word index, write enable, read enable, byte strobes, 32-bit write data, combinational read data) reaches a direction register and an output-data register. Each of these two registers also has clear, set and toggle aliases, so software can change single pins without a read-modify-write. The bus also reaches a control register that picks how each input pin is sampled, and a synchronized input register. Two byte-wide regions hold a mux-select nibble and a configuration byte for each pin.

A write-only bulk register gives one configuration byte and/or one mux selection to every pin picked by a 16-bit mask in either the lower or the upper half of the port, all in a single bus write. The per-pin output enable, output value, pull enable, input enable, drive-strength, mux-enable and mux-select lines leave the block as flat vectors for the pad ring and the peripheral multiplexer.

The block has no state machine. Each register is a plain clocked store that is updated from the decoded bus write. Byte offset = 4 x word index.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads zero and every pin output (pin_oe, pin_out, pin_pull_en, pin_in_en, pin_drive_hi, pin_mux_en, pin_mux_sel) is zero, so every pin is an input with all features off.
- R2: A write to the direction register (offset 0x00) or the output register (offset 0x10) loads the strobed bytes. pin_oe follows direction (1 = output, 0 = input) and pin_out follows output data from the next clock.
- R3: Writes to offsets 0x04/0x08/0x0C (direction) and 0x14/0x18/0x1C (output) clear, set or invert each base-register bit whose write-data bit is 1. Bits written 0 keep their value. A read of an alias returns its base register.
- R4: The input register (offset 0x20) returns pin_in after a two-flop synchronizer and a hold stage. A bit reads 0 while that pin's input enable is clear.
- R5: The control register (offset 0x24) is read/write. Where its bit is 1 the hold stage follows the synchronizer every clock (a pin change is readable three edges later). Where its bit is 0 the hold stage updates only on the edge of a read of offset 0x20.
- R6: Configuration bytes sit at offsets 0x40..0x5F, one byte per pin (pin p at byte 0x40+p). Bit 0 is mux enable, bit 1 input enable, bit 2 pull enable and bit 6 drive strength. Bits 7 and 5:3 read zero. Each bit drives the matching pin output.
- R7: Mux bytes sit at offsets 0x30..0x3F. Byte n holds pin 2n in bits 3:0 and pin 2n+1 in bits 7:4. Pin p's selection appears on pin_mux_sel[4p+3:4p].
- R8: A write to the bulk register (offset 0x28) uses bit 31 to pick pins 15..0 (0) or 31..16 (1) and bits 15:0 as the pin mask. Bit 30 copies drive (bit 22), pull (bit 18), input enable (bit 17) and mux enable (bit 16) into each masked pin's configuration. Bit 28 independently writes bits 27:24 as each masked pin's mux selection. Other pins keep their values.
- R9: The bulk register and every unmapped offset read zero.
- R10: Byte strobe k gates write-data bits 8k+7:8k for every register except the bulk register, which always takes the whole word. A write with no strobe set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_waddr | input | 6 | Word index (byte offset / 4) |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable (used for on-demand input sampling) |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_waddr |
| pin_in | input | 32 | Raw pin levels |
| pin_oe | output | 32 | Per-pin output enable (direction) |
| pin_out | output | 32 | Per-pin output value |
| pin_pull_en | output | 32 | Per-pin pull enable |
| pin_in_en | output | 32 | Per-pin input enable |
| pin_drive_hi | output | 32 | Per-pin strong drive select |
| pin_mux_en | output | 32 | Per-pin peripheral mux enable |
| pin_mux_sel | output | 128 | Per-pin 4-bit mux selection, pin p at [4p+3:4p] |

## Verification
Register writes take effect at the clock edge that samples them, so pin outputs and read-back are due one edge after a write. Read data is combinational on the current register state. A raw pin change reaches the input register three edges later in continuous mode; in on-demand mode it is held until the edge of a read of the input register. The bench applies stimulus at the falling edge. Its behavioural model is updated at the rising edge in the same order: hold stage from the old second stage, then the synchronizer shift, then the register write. The bench compares every output and the read data at the following falling edge, so each result is sampled in the cycle it is due.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Alias operation, encoded as the low two bits of the word index.
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    // Word indices (byte offset / 4).
    localparam logic [5:0] W_DIR   = 6'h00;
    localparam logic [5:0] W_OUT   = 6'h04;
    localparam logic [5:0] W_IN    = 6'h08;
    localparam logic [5:0] W_CTRL  = 6'h09;
    localparam logic [5:0] W_BULK  = 6'h0A;
    localparam logic [3:0] W_MUX_HI = 4'h3;   // words 0x0C..0x0F
    localparam logic [2:0] W_CFG_HI = 3'h2;   // words 0x10..0x17

    // Bit positions inside a configuration byte.
    localparam int CB_MUXEN = 0;
    localparam int CB_INEN  = 1;
    localparam int CB_PULL  = 2;
    localparam int CB_DRV   = 6;

    typedef struct packed {
        logic drv;
        logic pull;
        logic inen;
        logic muxen;
    } pin_cfg_t;

    // Decoded bulk command.
    typedef struct packed {
        logic        upper;
        logic        wr_cfg;
        logic        wr_mux;
        logic [3:0]  mux;
        pin_cfg_t    cfg;
        logic [15:0] mask;
    } bulk_cmd_t;

    function automatic logic [7:0] cfg_to_byte(input pin_cfg_t c);
        logic [7:0] b;
        b = 8'h00;
        b[CB_MUXEN] = c.muxen;
        b[CB_INEN]  = c.inen;
        b[CB_PULL]  = c.pull;
        b[CB_DRV]   = c.drv;
        return b;
    endfunction

    function automatic pin_cfg_t byte_to_cfg(input logic [7:0] b);
        pin_cfg_t c;
        c.muxen = b[CB_MUXEN];
        c.inen  = b[CB_INEN];
        c.pull  = b[CB_PULL];
        c.drv   = b[CB_DRV];
        return c;
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  alias_op_e        op,
    input  logic [WIDTH-1:0] bmask,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] hit;
    assign hit = wdata & bmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            unique case (op)
                OP_WRITE:  q <= (q & ~bmask) | hit;
                OP_CLEAR:  q <= q & ~hit;
                OP_SET:    q <= q | hit;
                OP_TOGGLE: q <= q ^ hit;
            endcase
        end
    end
endmodule

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] cont_mask,
    input  logic             demand,
    output logic [WIDTH-1:0] hold
);
    logic [WIDTH-1:0] s1, s2, upd;
    assign upd = cont_mask | {WIDTH{demand}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= '0;
            s2   <= '0;
            hold <= '0;
        end else begin
            s1   <= pin_in;
            s2   <= s1;
            hold <= (s2 & upd) | (hold & ~upd);
        end
    end
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int MUX_W  = 4,
    localparam int BPW     = DATA_W / 8,
    localparam int CFG_WDS = NPINS / BPW,
    localparam int MUX_WDS = (NPINS * MUX_W) / DATA_W,
    localparam int CSEL_W  = $clog2(CFG_WDS),
    localparam int MSEL_W  = $clog2(MUX_WDS),
    localparam int HALF    = NPINS / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [CSEL_W-1:0]      cfg_sel,
    input  logic                   mux_wr,
    input  logic [MSEL_W-1:0]      mux_sel,
    input  logic [BPW-1:0]         be,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   bulk_wr,
    input  bulk_cmd_t              bulk,
    output pin_cfg_t [NPINS-1:0]   cfg_q,
    output logic [NPINS*MUX_W-1:0] mux_q
);
    localparam int PPB = 8 / MUX_W;   // pins per mux byte

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int CW = p / BPW;
        localparam int CB = p % BPW;
        localparam int MW = p / (BPW * PPB);
        localparam int MB = (p % (BPW * PPB)) / PPB;
        localparam int MN = p % PPB;

        logic      bulk_hit;
        pin_cfg_t  c_r;
        logic [MUX_W-1:0] m_r;

        assign bulk_hit = bulk_wr && (bulk.upper == (p >= HALF)) && bulk.mask[p % HALF];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_r <= '0;
            end else if (bulk_hit && bulk.wr_cfg) begin
                c_r <= bulk.cfg;
            end else if (cfg_wr && cfg_sel == CSEL_W'(CW) && be[CB]) begin
                c_r <= byte_to_cfg(wdata[8*CB +: 8]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_r <= '0;
            end else if (bulk_hit && bulk.wr_mux) begin
                m_r <= bulk.mux;
            end else if (mux_wr && mux_sel == MSEL_W'(MW) && be[MB]) begin
                m_r <= wdata[8*MB + MUX_W*MN +: MUX_W];
            end
        end

        assign cfg_q[p]             = c_r;
        assign mux_q[MUX_W*p +: MUX_W] = m_r;
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WA_W   = 6,
    parameter int MUX_W  = 4,
    localparam int NPINS = DATA_W,
    localparam int BPW   = DATA_W / 8,
    localparam int CFG_WDS = NPINS / BPW,
    localparam int MUX_WDS = (NPINS * MUX_W) / DATA_W,
    localparam int CSEL_W  = $clog2(CFG_WDS),
    localparam int MSEL_W  = $clog2(MUX_WDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WA_W-1:0]        bus_waddr,
    input  logic                   bus_we,
    input  logic                   bus_re,
    input  logic [BPW-1:0]         bus_be,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NPINS-1:0]       pin_in,
    output logic [NPINS-1:0]       pin_oe,
    output logic [NPINS-1:0]       pin_out,
    output logic [NPINS-1:0]       pin_pull_en,
    output logic [NPINS-1:0]       pin_in_en,
    output logic [NPINS-1:0]       pin_drive_hi,
    output logic [NPINS-1:0]       pin_mux_en,
    output logic [NPINS*MUX_W-1:0] pin_mux_sel
);
    logic [DATA_W-1:0] bmask;
    for (genvar k = 0; k < BPW; k++) begin : g_bmask
        assign bmask[8*k +: 8] = {8{bus_be[k]}};
    end

    // Decode
    logic dir_wr, out_wr, ctrl_wr, bulk_wr, cfg_wr, mux_wr, in_demand;
    alias_op_e op;
    assign op        = alias_op_e'(bus_waddr[1:0]);
    assign dir_wr    = bus_we && (bus_waddr[WA_W-1:2] == W_DIR[WA_W-1:2]);
    assign out_wr    = bus_we && (bus_waddr[WA_W-1:2] == W_OUT[WA_W-1:2]);
    assign ctrl_wr   = bus_we && (bus_waddr == W_CTRL);
    assign bulk_wr   = bus_we && (bus_waddr == W_BULK);
    assign cfg_wr    = bus_we && (bus_waddr[WA_W-1:CSEL_W] == W_CFG_HI);
    assign mux_wr    = bus_we && (bus_waddr[WA_W-1:MSEL_W] == W_MUX_HI);
    assign in_demand = bus_re && (bus_waddr == W_IN);

    bulk_cmd_t bulk;
    assign bulk.upper     = bus_wdata[31];
    assign bulk.wr_cfg    = bus_wdata[30];
    assign bulk.wr_mux    = bus_wdata[28];
    assign bulk.mux       = bus_wdata[27:24];
    assign bulk.cfg.drv   = bus_wdata[22];
    assign bulk.cfg.pull  = bus_wdata[18];
    assign bulk.cfg.inen  = bus_wdata[17];
    assign bulk.cfg.muxen = bus_wdata[16];
    assign bulk.mask      = bus_wdata[15:0];

    // Storage
    logic [NPINS-1:0] dir_q, out_q, ctrl_q, in_hold;

    gpio_alias_reg #(.WIDTH(NPINS)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr(dir_wr), .op(op),
        .bmask(bmask), .wdata(bus_wdata), .q(dir_q)
    );

    gpio_alias_reg #(.WIDTH(NPINS)) u_out (
        .clk(clk), .rst_n(rst_n), .wr(out_wr), .op(op),
        .bmask(bmask), .wdata(bus_wdata), .q(out_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= (ctrl_q & ~bmask) | (bus_wdata & bmask);
        end
    end

    gpio_input_sync #(.WIDTH(NPINS)) u_insync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .cont_mask(ctrl_q), .demand(in_demand), .hold(in_hold)
    );

    pin_cfg_t [NPINS-1:0]   cfg_q;
    logic [NPINS*MUX_W-1:0] mux_q;

    gpio_pin_cfg #(.NPINS(NPINS), .DATA_W(DATA_W), .MUX_W(MUX_W)) u_pincfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(bus_waddr[CSEL_W-1:0]),
        .mux_wr(mux_wr), .mux_sel(bus_waddr[MSEL_W-1:0]),
        .be(bus_be), .wdata(bus_wdata),
        .bulk_wr(bulk_wr), .bulk(bulk),
        .cfg_q(cfg_q), .mux_q(mux_q)
    );

    // Pin outputs
    logic [DATA_W-1:0] cfg_word [CFG_WDS];
    for (genvar p = 0; p < NPINS; p++) begin : g_pinout
        assign pin_pull_en[p]  = cfg_q[p].pull;
        assign pin_in_en[p]    = cfg_q[p].inen;
        assign pin_drive_hi[p] = cfg_q[p].drv;
        assign pin_mux_en[p]   = cfg_q[p].muxen;
        assign cfg_word[p / BPW][8*(p % BPW) +: 8] = cfg_to_byte(cfg_q[p]);
    end
    assign pin_oe      = dir_q;
    assign pin_out     = out_q;
    assign pin_mux_sel = mux_q;

    // Read port
    always_comb begin
        bus_rdata = '0;
        if (bus_waddr[WA_W-1:2] == W_DIR[WA_W-1:2]) begin
            bus_rdata = dir_q;
        end else if (bus_waddr[WA_W-1:2] == W_OUT[WA_W-1:2]) begin
            bus_rdata = out_q;
        end else if (bus_waddr == W_IN) begin
            bus_rdata = in_hold & pin_in_en;
        end else if (bus_waddr == W_CTRL) begin
            bus_rdata = ctrl_q;
        end else if (bus_waddr[WA_W-1:CSEL_W] == W_CFG_HI) begin
            bus_rdata = cfg_word[bus_waddr[CSEL_W-1:0]];
        end else if (bus_waddr[WA_W-1:MSEL_W] == W_MUX_HI) begin
            bus_rdata = mux_q[DATA_W*int'(bus_waddr[MSEL_W-1:0]) +: DATA_W];
        end
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  bus_waddr,
    input logic        bus_we,
    input logic        bus_re,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] pin_oe,
    input logic [31:0] pin_out,
    input logic [31:0] pin_in_en,
    input logic        pull_p0,
    input logic [3:0]  mux_p0
);
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_waddr == 6'h00 && bus_be == 4'hF) |-> pin_oe == $past(bus_wdata));

    p_dir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_waddr == 6'h02 && bus_be == 4'hF) |-> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

    p_out_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_waddr == 6'h05 && bus_be == 4'hF) |-> ((pin_out & $past(bus_wdata)) == 32'h0));

    p_dir_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_oe));

    p_in_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_waddr == 6'h08) |-> ((bus_rdata & ~pin_in_en) == 32'h0));

    p_cfg_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr[5:3] == 3'b010) |-> ((bus_rdata & 32'hB8B8_B8B8) == 32'h0));

    p_mux_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_waddr == 6'h0C && bus_be[0]) |-> mux_p0 == $past(bus_wdata[3:0]));

    p_bulk_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_waddr == 6'h0A && !bus_wdata[31] && bus_wdata[30] && bus_wdata[0])
        |-> pull_p0 == $past(bus_wdata[18]));

    p_bulk_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr == 6'h0A) |-> bus_rdata == 32'h0);

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_waddr == 6'h00 && bus_be == 4'h0) |-> pin_oe == $past(pin_oe));
endmodule

bind gpio_port_regs gpio_port_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_in_en(pin_in_en), .pull_p0(pin_pull_en[0]), .mux_p0(pin_mux_sel[3:0])
);

// File: tb/gpio_port_regs_bench.sv
`timescale 1ns/1ps
module gpio_port_regs_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_waddr = '0;
    logic         bus_we = 1'b0;
    logic         bus_re = 1'b0;
    logic [3:0]   bus_be = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  pin_in = '0;
    logic [31:0]  pin_oe, pin_out, pin_pull_en, pin_in_en, pin_drive_hi, pin_mux_en;
    logic [127:0] pin_mux_sel;

    always #5 clk = ~clk;

    gpio_port_regs u_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pull_en(pin_pull_en), .pin_in_en(pin_in_en),
        .pin_drive_hi(pin_drive_hi), .pin_mux_en(pin_mux_en),
        .pin_mux_sel(pin_mux_sel)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference model
    bit [31:0] m_dir, m_out, m_ctrl, m_s1, m_s2, m_hold;
    bit [7:0]  m_cfg [32];
    bit [3:0]  m_mux [32];

    function automatic bit [31:0] strobe_mask(bit [3:0] be);
        bit [31:0] m = 0;
        for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic bit [31:0] apply_op(bit [31:0] cur, int op, bit [31:0] d, bit [31:0] bm);
        case (op)
            0: return (cur & ~bm) | (d & bm);
            1: return cur & ~(d & bm);
            2: return cur | (d & bm);
            default: return cur ^ (d & bm);
        endcase
    endfunction

    function automatic bit [31:0] inen_vec();
        bit [31:0] v = 0;
        for (int p = 0; p < 32; p++) v[p] = m_cfg[p][1];
        return v;
    endfunction

    function automatic bit [31:0] model_read(int w);
        bit [31:0] r = 0;
        if (w < 4) r = m_dir;
        else if (w < 8) r = m_out;
        else if (w == 8) r = m_hold & inen_vec();
        else if (w == 9) r = m_ctrl;
        else if (w >= 12 && w < 16)
            for (int j = 0; j < 4; j++) r[8*j +: 8] = {m_mux[2*((w-12)*4+j)+1], m_mux[2*((w-12)*4+j)]};
        else if (w >= 16 && w < 24)
            for (int j = 0; j < 4; j++) r[8*j +: 8] = m_cfg[(w-16)*4+j];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_ctrl = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
            for (int p = 0; p < 32; p++) begin m_cfg[p] = 0; m_mux[p] = 0; end
        end else begin
            automatic int w = int'(bus_waddr);
            automatic bit [31:0] bm = strobe_mask(bus_be);
            automatic bit [31:0] d = bus_wdata;
            for (int b = 0; b < 32; b++)
                if (m_ctrl[b] || (bus_re && w == 8)) m_hold[b] = m_s2[b];
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (bus_we) begin
                if (w < 4) m_dir = apply_op(m_dir, w, d, bm);
                else if (w < 8) m_out = apply_op(m_out, w - 4, d, bm);
                else if (w == 9) m_ctrl = (m_ctrl & ~bm) | (d & bm);
                else if (w == 10) begin
                    for (int p = 0; p < 32; p++) begin
                        if ((p / 16) == int'(d[31]) && d[p % 16]) begin
                            if (d[30]) m_cfg[p] = {1'b0, d[22], 3'b000, d[18], d[17], d[16]};
                            if (d[28]) m_mux[p] = d[27:24];
                        end
                    end
                end else if (w >= 12 && w < 16) begin
                    for (int j = 0; j < 4; j++) if (bus_be[j]) begin
                        m_mux[2*((w-12)*4+j)]   = d[8*j +: 4];
                        m_mux[2*((w-12)*4+j)+1] = d[8*j+4 +: 4];
                    end
                end else if (w >= 16 && w < 24) begin
                    for (int j = 0; j < 4; j++)
                        if (bus_be[j]) m_cfg[(w-16)*4+j] = d[8*j +: 8] & 8'h47;
                end
            end
        end
    end

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string read_tag(int w);
        if (w == 0 || w == 4) return "R2/R10";
        if (w < 8) return "R3";
        if (w == 8) return "R4/R5";
        if (w == 9) return "R5";
        if (w >= 12 && w < 16) return "R7";
        if (w >= 16 && w < 24) return "R6";
        return "R9";
    endfunction

    task automatic compare_all(bit reset_phase);
        bit [31:0] e_pull, e_inen, e_drv, e_muxen;
        bit [127:0] e_sel;
        for (int p = 0; p < 32; p++) begin
            e_muxen[p] = m_cfg[p][0];
            e_inen[p]  = m_cfg[p][1];
            e_pull[p]  = m_cfg[p][2];
            e_drv[p]   = m_cfg[p][6];
            e_sel[4*p +: 4] = m_mux[p];
        end
        chk(reset_phase ? "R1" : "R2/R3/R10", "pin_oe", 128'(pin_oe), 128'(m_dir));
        chk(reset_phase ? "R1" : "R2/R3/R10", "pin_out", 128'(pin_out), 128'(m_out));
        chk(reset_phase ? "R1" : "R6/R8", "pin_pull_en", 128'(pin_pull_en), 128'(e_pull));
        chk(reset_phase ? "R1" : "R6/R8", "pin_in_en", 128'(pin_in_en), 128'(e_inen));
        chk(reset_phase ? "R1" : "R6/R8", "pin_drive_hi", 128'(pin_drive_hi), 128'(e_drv));
        chk(reset_phase ? "R1" : "R6/R8", "pin_mux_en", 128'(pin_mux_en), 128'(e_muxen));
        chk(reset_phase ? "R1" : "R7/R8", "pin_mux_sel", pin_mux_sel, e_sel);
        chk(reset_phase ? "R1" : read_tag(int'(bus_waddr)), "bus_rdata",
            128'(bus_rdata), 128'(model_read(int'(bus_waddr))));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: sweep every word with no writes after reset
        for (int w = 0; w < 26; w++) begin
            bus_waddr = 6'(w);
            bus_re = 1'b1;
            @(negedge clk);
            compare_all(1'b1);
        end
        // Directed: set ctrl bit continuous and enable inputs (R5, R4)
        bus_we = 1'b1; bus_be = 4'hF;
        bus_waddr = 6'h09; bus_wdata = 32'h0000_FFFF;
        @(negedge clk); compare_all(1'b0);
        bus_waddr = 6'h0A; bus_wdata = 32'h4002_FFFF;   // R8 lower half input enable
        @(negedge clk); compare_all(1'b0);
        bus_waddr = 6'h0A; bus_wdata = 32'h9005_00F0;   // R8 upper half mux only
        @(negedge clk); compare_all(1'b0);
        bus_we = 1'b0; bus_re = 1'b1; bus_waddr = 6'h08;
        pin_in = 32'hA5A5_5A5A;
        for (int i = 0; i < 5; i++) begin @(negedge clk); compare_all(1'b0); end
        // Random phase
        for (int i = 0; i < 6000; i++) begin
            automatic int w = $urandom_range(0, 24);
            if (w == 24) w = 31;
            bus_we = ($urandom % 3) != 0;
            bus_re = ($urandom % 2) != 0;
            if ($urandom % 5 == 0) begin w = 8; bus_we = 1'b0; bus_re = 1'b1; end
            bus_waddr = 6'(w);
            bus_be = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            bus_wdata = $urandom;
            if (w == 10 && ($urandom % 2) != 0) bus_wdata[15:0] = bus_wdata[15:0] & 16'($urandom);
            if ($urandom % 6 == 0) pin_in = $urandom;
            @(negedge clk);
            compare_all(1'b0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule